// File: doc/BRIEF.md
# Lane Test Pattern Source

This block chooses the 10-bit character that a serializer lane transmits on each character clock. Besides the normal encoded data, it can send a constant zero, a pseudo-random bit sequence, or a programmable sequence of eight 10-bit words. Link bring-up and bit-error testing use it to put known traffic on the wire without changing the upstream encoder.

The pseudo-random engine provides four polynomials. Each polynomial has its own shift register, and only the selected one advances. A width field sets how many fresh bits are produced per character: none, 1, 8 or 10. The word engine steps through its eight words in order and wraps back to the first. Each word can be held for one to eight clocks. The chosen source goes through one output register, so every result appears one clock after the inputs that produced it.

Top module: `lane_pattern_mux`

## Requirements
- R1: While `rst` is high at a clock edge, `lane_out` becomes 0, every sequence register is loaded with all ones, and the word index and hold counter return to 0.
- R2: `lane_sel` = 3'b001 makes `lane_out` equal to the `data_in` value sampled one clock earlier. 3'b000 and every code other than 001, 010 and 100 give an all-zero output.
- R3: `lane_sel` = 3'b010 selects the pseudo-random source. `prbs_poly` 0 selects x^11+x^9+1, 1 selects x^15+x^14+1, 2 selects x^7+x^6+1 and 3 selects x^31+x^28+1. Each register of length L shifts toward its MSB. The bit entering bit 0 is the XOR of bit L-1 and the bit at the lower tap position minus one, and that new bit is the emitted bit.
- R4: `prbs_width` 1 emits 8 bits on `lane_out[7:0]` with bits 9:8 at 0. Width 2 emits 1 bit on bit 0 with bits 9:1 at 0. Width 3 emits 10 bits. Width 0 outputs zero and does not advance. The first bit generated in a clock goes to bit 0, and the register advances by exactly the number of bits emitted.
- R5: With `prbs_en` low, the pseudo-random source outputs zero and no sequence register changes. The sequence resumes where it stopped. A polynomial that is not selected never advances.
- R6: `lane_sel` = 3'b100 outputs pattern word k, which is `shift_words[79-10k:70-10k]`. Word 0 appears first after the engine is enabled.
- R7: With hold value H, each word is output for H+1 consecutive clocks, and the index wraps from word 7 to word 0.
- R8: With `shift_en` low, the word source outputs zero and the index and hold counter clear. Re-enabling starts again at word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst | input | 1 | Synchronous active-high reset |
| data_in | input | 10 | Normal encoded character |
| lane_sel | input | 3 | Source select (000 zero, 001 data, 010 pseudo-random, 100 words) |
| prbs_en | input | 1 | Pseudo-random engine enable |
| prbs_poly | input | 2 | Polynomial choice |
| prbs_width | input | 2 | Bits emitted per clock (0 none, 1 eight, 2 one, 3 ten) |
| shift_en | input | 1 | Word engine enable |
| shift_hold | input | 3 | Extra clocks each word is held |
| shift_words | input | 80 | Eight packed 10-bit words, word 0 in the top bits |
| lane_out | output | 10 | Registered lane character |

## Verification
The bound assertions check the output on every cycle in several cases: the pass-through of data, zero output for the zero code and the undefined codes, zero output from a disabled engine, and the upper bits that must stay clear in the 8-bit and 1-bit widths. Only the bench's scenarios can show the actual bit sequence of each polynomial. The same holds for register hold across disable periods and polynomial switches, the word order with hold counts, the wrap from word 7, and the return to word 0 after disable or reset. For these the bench compares the output against a behavioural model on every clock.

// File: rtl/lpg_pkg.sv
package lpg_pkg;
  localparam logic [2:0] SEL_ZERO  = 3'b000;
  localparam logic [2:0] SEL_DATA  = 3'b001;
  localparam logic [2:0] SEL_PRBS  = 3'b010;
  localparam logic [2:0] SEL_SHIFT = 3'b100;

  localparam logic [1:0] WID_IDLE = 2'd0;
  localparam logic [1:0] WID_BYTE = 2'd1;
  localparam logic [1:0] WID_ONE  = 2'd2;
  localparam logic [1:0] WID_FULL = 2'd3;

  localparam int NUM_POLY = 4;

  // register length per polynomial code
  function automatic int poly_len(input int code);
    case (code)
      0: return 11;
      1: return 15;
      2: return 7;
      default: return 31;
    endcase
  endfunction

  // second tap position per polynomial code
  function automatic int poly_tap(input int code);
    case (code)
      0: return 9;
      1: return 14;
      2: return 6;
      default: return 28;
    endcase
  endfunction
endpackage

// File: rtl/lpg_prbs.sv
module lpg_prbs #(
  parameter int LEN   = 7,
  parameter int TAP   = 6,
  parameter int WW    = 10,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_en,
  input  logic [CNT_W-1:0] steps,
  output logic [WW-1:0]    bits
);
  logic [LEN-1:0] state;
  logic [LEN-1:0] walk;
  logic [LEN-1:0] nxt;

  // unroll WW steps; keep the state reached after `steps` of them
  always_comb begin
    walk = state;
    nxt  = state;
    bits = '0;
    for (int i = 0; i < WW; i++) begin
      bits[i] = walk[LEN-1] ^ walk[TAP-1];
      walk    = {walk[LEN-2:0], bits[i]};
      if (CNT_W'(i + 1) == steps) nxt = walk;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          state <= {LEN{1'b1}};
    else if (step_en) state <= nxt;
  end
endmodule

// File: rtl/lpg_shift.sv
module lpg_shift #(
  parameter int WW     = 10,
  parameter int NWORDS = 8,
  parameter int RPT_W  = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic [RPT_W-1:0]     hold,
  input  logic [NWORDS*WW-1:0] words,
  output logic [WW-1:0]        word
);
  localparam int IDX_W = (NWORDS > 1) ? $clog2(NWORDS) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NWORDS - 1);

  logic [IDX_W-1:0] idx;
  logic [RPT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      idx <= '0;
      cnt <= '0;
    end else if (cnt == hold) begin
      cnt <= '0;
      idx <= (idx == LAST) ? '0 : idx + 1'b1;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // word 0 sits in the most significant slice
  always_comb begin
    word = '0;
    if (en) word = words[(NWORDS - 1 - int'(idx)) * WW +: WW];
  end
endmodule

// File: rtl/lane_pattern_mux.sv
module lane_pattern_mux
  import lpg_pkg::*;
#(
  parameter int WW     = 10,
  parameter int NWORDS = 8,
  parameter int RPT_W  = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [WW-1:0]        data_in,
  input  logic [2:0]           lane_sel,
  input  logic                 prbs_en,
  input  logic [1:0]           prbs_poly,
  input  logic [1:0]           prbs_width,
  input  logic                 shift_en,
  input  logic [RPT_W-1:0]     shift_hold,
  input  logic [NWORDS*WW-1:0] shift_words,
  output logic [WW-1:0]        lane_out
);
  localparam int CNT_W = $clog2(WW + 1);

  logic [CNT_W-1:0] steps;
  logic [WW-1:0]    prbs_bits [NUM_POLY];
  logic [WW-1:0]    prbs_word;
  logic [WW-1:0]    shift_word;

  always_comb begin
    case (prbs_width)
      WID_BYTE: steps = CNT_W'(8);
      WID_ONE:  steps = CNT_W'(1);
      WID_FULL: steps = CNT_W'(WW);
      default:  steps = '0;
    endcase
  end

  for (genvar g = 0; g < NUM_POLY; g++) begin : g_poly
    lpg_prbs #(
      .LEN(poly_len(g)), .TAP(poly_tap(g)), .WW(WW), .CNT_W(CNT_W)
    ) u_prbs (
      .clk(clk), .rst(rst),
      .step_en(prbs_en && (prbs_poly == 2'(g))),
      .steps(steps),
      .bits(prbs_bits[g])
    );
  end

  always_comb begin
    prbs_word = '0;
    for (int i = 0; i < WW; i++)
      if (prbs_en && (CNT_W'(i) < steps)) prbs_word[i] = prbs_bits[prbs_poly][i];
  end

  lpg_shift #(.WW(WW), .NWORDS(NWORDS), .RPT_W(RPT_W)) u_shift (
    .clk(clk), .rst(rst), .en(shift_en), .hold(shift_hold),
    .words(shift_words), .word(shift_word)
  );

  always_ff @(posedge clk) begin
    if (rst) lane_out <= '0;
    else begin
      case (lane_sel)
        SEL_DATA:  lane_out <= data_in;
        SEL_PRBS:  lane_out <= prbs_word;
        SEL_SHIFT: lane_out <= shift_word;
        default:   lane_out <= '0;
      endcase
    end
  end
endmodule

// File: rtl/lpg_checker.sv
module lpg_checker
  import lpg_pkg::*;
#(
  parameter int WW = 10
) (
  input logic          clk,
  input logic          rst,
  input logic [WW-1:0] data_in,
  input logic [2:0]    lane_sel,
  input logic          prbs_en,
  input logic [1:0]    prbs_width,
  input logic          shift_en,
  input logic [WW-1:0] lane_out
);
  // R1
  reset_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> lane_out == '0);

  // R2
  data_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(lane_sel) == SEL_DATA) |-> lane_out == $past(data_in));

  // R2
  bad_code_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (!$onehot0($past(lane_sel)) || $past(lane_sel) == SEL_ZERO))
      |-> lane_out == '0);

  // R4
  byte_top_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(lane_sel) == SEL_PRBS && $past(prbs_width) == WID_BYTE)
      |-> lane_out[WW-1:8] == '0);

  // R4
  one_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(lane_sel) == SEL_PRBS && $past(prbs_width) == WID_ONE)
      |-> lane_out[WW-1:1] == '0);

  // R5
  prbs_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(lane_sel) == SEL_PRBS && !$past(prbs_en)) |-> lane_out == '0);

  // R8
  shift_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(lane_sel) == SEL_SHIFT && !$past(shift_en)) |-> lane_out == '0);
endmodule

bind lane_pattern_mux lpg_checker #(.WW(WW)) u_lpg_checker (
  .clk(clk), .rst(rst), .data_in(data_in), .lane_sel(lane_sel),
  .prbs_en(prbs_en), .prbs_width(prbs_width), .shift_en(shift_en),
  .lane_out(lane_out)
);

// File: tb/test_lane_pattern_mux.sv
`timescale 1ns/1ps
module test_lane_pattern_mux;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [9:0]  data_in = '0;
  logic [2:0]  lane_sel = '0;
  logic        prbs_en = 1'b0;
  logic [1:0]  prbs_poly = '0;
  logic [1:0]  prbs_width = '0;
  logic        shift_en = 1'b0;
  logic [2:0]  shift_hold = '0;
  logic [79:0] shift_words = '0;
  logic [9:0]  lane_out;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  lane_pattern_mux i_lane_pattern_mux (
    .clk(clk), .rst(rst), .data_in(data_in), .lane_sel(lane_sel),
    .prbs_en(prbs_en), .prbs_poly(prbs_poly), .prbs_width(prbs_width),
    .shift_en(shift_en), .shift_hold(shift_hold), .shift_words(shift_words),
    .lane_out(lane_out)
  );

  // behavioural reference model
  logic [31:0] ms [4];
  logic [9:0]  exp_out = '0;
  string       exp_tag = "R1";
  bit          live = 0;
  int          m_idx = 0;
  int          m_cnt = 0;
  int          len_tab [4] = '{11, 15, 7, 31};
  int          tap_tab [4] = '{9, 14, 6, 28};

  always @(posedge clk) begin
    logic [31:0] st;
    logic [9:0]  pw, sw;
    int n, L, T;
    logic fb;
    live = 1;
    if (rst) begin
      for (int m = 0; m < 4; m++) ms[m] = (32'h1 << len_tab[m]) - 1;
      m_idx = 0; m_cnt = 0; exp_out = '0; exp_tag = "R1";
    end else begin
      n = (prbs_width == 2'd1) ? 8 : (prbs_width == 2'd2) ? 1 : (prbs_width == 2'd3) ? 10 : 0;
      L = len_tab[prbs_poly]; T = tap_tab[prbs_poly];
      st = ms[prbs_poly]; pw = '0;
      for (int i = 0; i < n; i++) begin
        fb = st[L-1] ^ st[T-1];
        pw[i] = fb;
        st = ((st << 1) | 32'(fb)) & ((32'h1 << L) - 1);
      end
      if (prbs_en) ms[prbs_poly] = st; else pw = '0;
      sw = shift_en ? shift_words[79 - 10*m_idx -: 10] : 10'd0;
      if (!shift_en) begin m_idx = 0; m_cnt = 0; end
      else if (m_cnt == int'(shift_hold)) begin m_cnt = 0; m_idx = (m_idx + 1) % 8; end
      else m_cnt++;
      case (lane_sel)
        3'b001: begin exp_out = data_in; exp_tag = "R2"; end
        3'b010: begin exp_out = pw; exp_tag = !prbs_en ? "R5" : (n == 10) ? "R3" : "R4"; end
        3'b100: begin exp_out = sw; exp_tag = !shift_en ? "R8" : (shift_hold == 0) ? "R6" : "R7"; end
        default: begin exp_out = '0; exp_tag = "R2"; end
      endcase
    end
  end

  task automatic check(input string tag, input logic [9:0] act, input logic [9:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s lane_out=%h expected=%h at %0t", tag, act, expv, $time);
    end
  endtask

  always @(negedge clk) if (live && !finished) check(exp_tag, lane_out, exp_out);

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    for (int k = 0; k < 8; k++) shift_words[79 - 10*k -: 10] = 10'(k * 69 + 19);
    run(3);
    check("R1", lane_out, 10'd0);
    rst = 1'b0;
    // R2 data path
    lane_sel = 3'b001;
    for (int i = 0; i < 20; i++) begin data_in = 10'(i * 37 + 5); run(1); end
    data_in = 10'h3ff; run(2);
    lane_sel = 3'b000; run(4);
    lane_sel = 3'b011; run(3);
    lane_sel = 3'b111; run(3);
    lane_sel = 3'b101; run(3);
    // R3 / R4 every polynomial and width
    lane_sel = 3'b010; prbs_en = 1'b1;
    for (int p = 0; p < 4; p++)
      for (int w = 0; w < 4; w++) begin
        prbs_poly = 2'(p); prbs_width = 2'(w); run(12);
      end
    // R5 hold while disabled, resume afterward
    prbs_poly = 2'd3; prbs_width = 2'd3;
    prbs_en = 1'b0; run(10);
    prbs_en = 1'b1; run(10);
    prbs_poly = 2'd2; run(10);
    // R6 word order from word 0
    lane_sel = 3'b100; shift_hold = 3'd0; run(3);
    shift_en = 1'b1;
    run(1); check("R6", lane_out, shift_words[79:70]);
    run(1); check("R6", lane_out, shift_words[69:60]);
    run(20);
    // R7 hold counts and wrap
    shift_hold = 3'd3; run(40);
    shift_hold = 3'd7; run(70);
    // R8 disable clears index
    shift_en = 1'b0; run(3);
    shift_hold = 3'd1; shift_en = 1'b1;
    run(1); check("R8", lane_out, shift_words[79:70]);
    run(20);
    for (int k = 0; k < 8; k++) shift_words[79 - 10*k -: 10] = 10'(k * 113 + 7);
    run(12);
    // R1 reset in mid-run
    rst = 1'b1; run(2);
    check("R1", lane_out, 10'd0);
    rst = 1'b0; lane_sel = 3'b010; prbs_poly = 2'd0; run(12);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog expired, lane_out=%h expected=end of run", lane_out);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule